// File: doc/BRIEF.md
# Conversion Result Window Monitor

This block watches the stream of finished conversion results from a converter and raises a sticky flag when a guarded result falls outside a programmable window bounded by a high and a low 12-bit threshold. Each result arrives with a valid strobe, the channel number it came from and a tag that says whether it belongs to the regular or the injected group.

The guard can cover every channel or only one chosen channel. It can apply to regular results, injected results or both, through two independent enables. Combined with the channel-scope select, these give seven distinct modes, counting "off". Software polls the flag or lets it drive an interrupt, and clears it by writing a zero to it.

Top module: `win_watchdog`

## Requirements
- R1: After reset, flag_o and irq_o are low.
- R2: A guarded result is out of window when it is strictly above cfg_hi_i or strictly below cfg_lo_i, both compared as unsigned 12-bit values. A result equal to either threshold is inside the window.
- R3: A result with res_inj_i=0 (regular) is guarded only when cfg_reg_en_i=1. A result with res_inj_i=1 (injected) is guarded only when cfg_inj_en_i=1. With both enables low, the monitor never sets the flag.
- R4: With cfg_single_i=1, only results whose res_chan_i equals cfg_chan_i are guarded, and a cfg_chan_i above 18 matches no result. With cfg_single_i=0, cfg_chan_i has no effect.
- R5: The flag is set on the clock edge that ends the cycle in which res_valid_i is high with an out-of-window guarded result. With res_valid_i low, nothing sets the flag.
- R6: Once set, the flag stays high while later results are inside the window.
- R7: flag_wr_i=1 with flag_wdata_i=0 clears the flag on the next edge. flag_wr_i=1 with flag_wdata_i=1 leaves the flag unchanged.
- R8: If a clear write and a new out-of-window event fall in the same cycle, the flag ends up set.
- R9: irq_o is high exactly when the flag is set and cfg_irq_en_i=1. With cfg_irq_en_i=0 the flag still sets and can be polled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| res_valid_i | input | 1 | Conversion result valid strobe |
| res_data_i | input | 12 | Conversion result |
| res_chan_i | input | 5 | Channel number of the result |
| res_inj_i | input | 1 | Group tag: 0 regular, 1 injected |
| cfg_hi_i | input | 12 | High threshold |
| cfg_lo_i | input | 12 | Low threshold |
| cfg_chan_i | input | 5 | Guarded channel in single-channel mode |
| cfg_single_i | input | 1 | 1 guards one channel, 0 guards all |
| cfg_reg_en_i | input | 1 | Guard regular results |
| cfg_inj_en_i | input | 1 | Guard injected results |
| cfg_irq_en_i | input | 1 | Interrupt enable |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Written flag value: 0 clears, 1 keeps |
| flag_o | output | 1 | Sticky out-of-window flag |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check that the flag rises only one edge after a guarded hit, and that a hit always sets it, including a hit in the same cycle as a clear. They also check that the flag holds unless a zero is written, that a zero write without a hit clears it, that no hit occurs with both group enables low or without a valid strobe, and that the interrupt never fires without both the flag and its enable. Some behaviour depends on the data values, and only the bench's scenarios exercise it. This covers the threshold-equality corners and the channel match and mismatch cases, including a configured channel above the legal range. It also covers the scope select that makes the channel setting irrelevant, and the rule that a written one does nothing. The cycle-by-cycle model confirms all of these.

// File: rtl/win_wdg_pkg.sv
package win_wdg_pkg;
  localparam int unsigned NUM_GRP = 2;
  typedef enum logic {
    GRP_REGULAR  = 1'b0,
    GRP_INJECTED = 1'b1
  } grp_e;
endpackage

// File: rtl/wdg_qualify.sv
module wdg_qualify
  import win_wdg_pkg::*;
#(
  parameter int unsigned CHAN_W   = 5,
  parameter int unsigned CHAN_MAX = 18
) (
  input  logic              valid_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              inj_i,
  input  logic [CHAN_W-1:0] cfg_chan_i,
  input  logic              cfg_single_i,
  input  logic              cfg_reg_en_i,
  input  logic              cfg_inj_en_i,
  output logic              guard_o
);
  localparam logic [CHAN_W-1:0] CHAN_LIMIT = CHAN_W'(CHAN_MAX);

  logic [NUM_GRP-1:0] grp_en;
  logic [NUM_GRP-1:0] grp_sel;
  logic               chan_ok;

  assign grp_en[GRP_REGULAR]  = cfg_reg_en_i;
  assign grp_en[GRP_INJECTED] = cfg_inj_en_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_sel[g] = grp_en[g] && (inj_i == 1'(g));
  end

  // illegal configured channel never matches
  assign chan_ok = !cfg_single_i ||
                   ((cfg_chan_i <= CHAN_LIMIT) && (chan_i == cfg_chan_i));
  assign guard_o = valid_i && chan_ok && |grp_sel;
endmodule

// File: rtl/wdg_window.sv
module wdg_window #(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  output logic              outside_o
);
  logic above, below;
  assign above     = data_i > hi_i;
  assign below     = data_i < lo_i;
  assign outside_o = above || below;
endmodule

// File: rtl/wdg_sticky.sv
module wdg_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // new event beats a clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned CHAN_W   = 5,
  parameter int unsigned CHAN_MAX = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic [CHAN_W-1:0] res_chan_i,
  input  logic              res_inj_i,
  input  logic [DATA_W-1:0] cfg_hi_i,
  input  logic [DATA_W-1:0] cfg_lo_i,
  input  logic [CHAN_W-1:0] cfg_chan_i,
  input  logic              cfg_single_i,
  input  logic              cfg_reg_en_i,
  input  logic              cfg_inj_en_i,
  input  logic              cfg_irq_en_i,
  input  logic              flag_wr_i,
  input  logic              flag_wdata_i,
  output logic              flag_o,
  output logic              irq_o
);
  logic guarded, outside, guard_hit, clr_req;

  wdg_qualify #(.CHAN_W(CHAN_W), .CHAN_MAX(CHAN_MAX)) u_qual (
    .valid_i      (res_valid_i),
    .chan_i       (res_chan_i),
    .inj_i        (res_inj_i),
    .cfg_chan_i   (cfg_chan_i),
    .cfg_single_i (cfg_single_i),
    .cfg_reg_en_i (cfg_reg_en_i),
    .cfg_inj_en_i (cfg_inj_en_i),
    .guard_o      (guarded)
  );

  wdg_window #(.DATA_W(DATA_W)) u_win (
    .data_i    (res_data_i),
    .hi_i      (cfg_hi_i),
    .lo_i      (cfg_lo_i),
    .outside_o (outside)
  );

  assign guard_hit = guarded && outside;
  assign clr_req   = flag_wr_i && !flag_wdata_i;

  wdg_sticky u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (guard_hit),
    .clr_i  (clr_req),
    .flag_o (flag_o)
  );

  assign irq_o = flag_o && cfg_irq_en_i;
endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic res_valid_i,
  input logic cfg_reg_en_i,
  input logic cfg_inj_en_i,
  input logic cfg_irq_en_i,
  input logic flag_wr_i,
  input logic flag_wdata_i,
  input logic guard_hit,
  input logic flag_o,
  input logic irq_o
);
  AST_HIT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    guard_hit |=> flag_o);                                               // R5
  AST_SET_OVER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (guard_hit && flag_wr_i && !flag_wdata_i) |=> flag_o);               // R8
  AST_RISE_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(guard_hit));                                 // R5
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !(flag_wr_i && !flag_wdata_i)) |=> flag_o);               // R6
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_wr_i && !flag_wdata_i && !guard_hit) |=> !flag_o);             // R7
  AST_OFF_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    guard_hit |-> ((cfg_reg_en_i || cfg_inj_en_i) && res_valid_i));      // R3
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && cfg_irq_en_i));                                 // R9
endmodule

bind win_watchdog win_watchdog_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .res_valid_i  (res_valid_i),
  .cfg_reg_en_i (cfg_reg_en_i),
  .cfg_inj_en_i (cfg_inj_en_i),
  .cfg_irq_en_i (cfg_irq_en_i),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .guard_hit    (guard_hit),
  .flag_o       (flag_o),
  .irq_o        (irq_o)
);

// File: tb/win_watchdog_bench.sv
`timescale 1ns/1ps
module win_watchdog_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, inj = 1'b0;
  logic [11:0] data = '0, hi = 12'hC00, lo = 12'h100;
  logic [4:0] chan = '0, cchan = '0;
  logic single = 1'b0, reg_en = 1'b0, inj_en = 1'b0, irq_en = 1'b0;
  logic wr = 1'b0, wdata = 1'b1;
  logic flag, irq;

  int checks = 0, errors = 0, cycles = 0;
  bit cmp_on = 1'b0, done = 1'b0;
  bit m_flag = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  win_watchdog u_win_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(valid), .res_data_i(data),
    .res_chan_i(chan), .res_inj_i(inj), .cfg_hi_i(hi), .cfg_lo_i(lo),
    .cfg_chan_i(cchan), .cfg_single_i(single), .cfg_reg_en_i(reg_en),
    .cfg_inj_en_i(inj_en), .cfg_irq_en_i(irq_en), .flag_wr_i(wr),
    .flag_wdata_i(wdata), .flag_o(flag), .irq_o(irq)
  );

  // behavioural reference
  always @(posedge clk) begin
    int d, h, l;
    bit grp_ok, ch_ok, hit;
    d = int'(data); h = int'(hi); l = int'(lo);
    grp_ok = inj ? inj_en : reg_en;
    ch_ok  = !single || (int'(cchan) <= 18 && chan == cchan);
    hit    = valid && grp_ok && ch_ok && (d > h || d < l);
    if (!rst_n)              m_flag = 1'b0;
    else if (hit)            m_flag = 1'b1;
    else if (wr && !wdata)   m_flag = 1'b0;
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      check({cur_req, " flag"}, flag, m_flag);
      check({cur_req, " irq"}, irq, m_flag & irq_en);
    end
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic result(input logic [11:0] d, input logic [4:0] c, input logic g);
    step(); valid = 1'b1; data = d; chan = c; inj = g;
    step(); valid = 1'b0;
  endtask

  task automatic clear(input logic v);
    step(); wr = 1'b1; wdata = v;
    step(); wr = 1'b0; wdata = 1'b1;
  endtask

  initial begin
    repeat (3) step();
    cur_req = "R1";
    check("R1 reset flag", flag, 1'b0);
    check("R1 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    step();
    // R3: off mode, nothing sets
    cur_req = "R3";
    result(12'hFFF, 5'd3, 1'b0);
    result(12'h000, 5'd3, 1'b1);
    // R2: thresholds are inside, all-channel regular
    cur_req = "R2";
    reg_en = 1'b1;
    result(12'hC00, 5'd1, 1'b0);
    result(12'h100, 5'd1, 1'b0);
    result(12'h800, 5'd1, 1'b0);
    check("R2 equal thresholds inside", flag, 1'b0);
    // R3: injected ignored when only regular enabled
    cur_req = "R3";
    result(12'hFFF, 5'd1, 1'b1);
    check("R3 injected not guarded", flag, 1'b0);
    // R2/R5: just above high sets
    cur_req = "R5";
    step(); valid = 1'b1; data = 12'hC01; chan = 5'd2; inj = 1'b0;
    step(); valid = 1'b0;
    check("R5 set after one edge", flag, 1'b1);
    // R6: in-window result keeps it
    cur_req = "R6";
    result(12'h500, 5'd2, 1'b0);
    check("R6 sticky", flag, 1'b1);
    // R7: write one keeps, write zero clears
    cur_req = "R7";
    clear(1'b1);
    check("R7 write one keeps", flag, 1'b1);
    clear(1'b0);
    check("R7 write zero clears", flag, 1'b0);
    // R2: just below low, injected path only
    cur_req = "R2";
    reg_en = 1'b0; inj_en = 1'b1;
    result(12'h0FF, 5'd7, 1'b0);
    check("R3 regular not guarded", flag, 1'b0);
    result(12'h0FF, 5'd7, 1'b1);
    check("R2 below low sets", flag, 1'b1);
    clear(1'b0);
    // R4: single channel
    cur_req = "R4";
    reg_en = 1'b1; single = 1'b1; cchan = 5'd18;
    result(12'hFFF, 5'd5, 1'b0);
    check("R4 other channel ignored", flag, 1'b0);
    result(12'hFFF, 5'd18, 1'b1);
    check("R4 match channel 18", flag, 1'b1);
    clear(1'b0);
    cchan = 5'd20;
    result(12'hFFF, 5'd20, 1'b0);
    check("R4 illegal channel matches nothing", flag, 1'b0);
    single = 1'b0;
    result(12'hFFF, 5'd9, 1'b0);
    check("R4 all-channel ignores setting", flag, 1'b1);
    // R9: interrupt gating
    cur_req = "R9";
    irq_en = 1'b1;
    step();
    check("R9 irq with enable", irq, 1'b1);
    irq_en = 1'b0;
    step();
    check("R9 irq masked, flag polled", irq, 1'b0);
    irq_en = 1'b1;
    clear(1'b0);
    check("R9 irq follows clear", irq, 1'b0);
    // R8: set and clear in the same cycle
    cur_req = "R8";
    step(); valid = 1'b1; data = 12'h001; chan = 5'd0; inj = 1'b0; wr = 1'b1; wdata = 1'b0;
    step(); valid = 1'b0; wr = 1'b0; wdata = 1'b1;
    check("R8 set wins", flag, 1'b1);
    // R5: data out of window without valid
    cur_req = "R5";
    clear(1'b0);
    step(); data = 12'hFFF;
    step(); step();
    check("R5 no valid no set", flag, 1'b0);
    // R1: async reset clears
    cur_req = "R1";
    result(12'hFFF, 5'd0, 1'b0);
    cmp_on = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 async reset", flag, 1'b0);
    step(); rst_n = 1'b1;
    step();
    cmp_on = 1'b1;
    repeat (3) step();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule